// File: doc/BRIEF.md
# MMU Register Move Controller

This block executes the two-word privileged instruction that copies data between memory and the control registers of a memory management unit. It owns six registers: a CPU root pointer and a supervisor root pointer of 64 bits each, a 32-bit translation control register, two 32-bit transparent translation registers and a 16-bit status register. The issuing pipeline presents both instruction words, the current privilege level and, for a load, the operand already fetched from memory. The block decodes the words, checks the addressing mode, and then either commits the operand to the selected register or drives the register value toward memory for a store.

Loads are committed even when the value is inconsistent. A root pointer with an invalid descriptor type, or a translation control value whose field widths do not add up, is written and reported through a separate configuration-error pulse. Unless the instruction sets its flush-disable flag, a load also requests a flush of the translation cache. Bad encodings and user-mode execution raise exceptions and write nothing. Every result appears as one-cycle pulses in the cycle after the instruction is presented.

Top module: `mmu_move_unit`

## Requirements
- R1: The first word is accepted only when bits 15..6 equal 1111000000 and the mode field (bits 5..3) is 010, 101 or 110, or is 111 with register field (bits 2..0) 000 or 001. Any other first word raises excIllegal and nothing is written or stored.
- R2: In the second word, bits 15..13 = 010 with bits 7..0 zero select via bits 12..10 translation control (000), supervisor root (010) or CPU root (011). Bits 15..13 = 000 with bits 7..0 zero select transparent translation 0 (010) or 1 (011). Bits 15..10 = 011000 with bits 8..0 zero select the status register. Any other second word raises excIllegal.
- R3: An instruction presented with supervisor low raises excPriv, never excIllegal, and changes no register.
- R4: A load writes the selected register from loadData: all 64 bits for the root pointers, bits 31..0 for the translation control and transparent translation registers, bits 15..0 for the status register.
- R5: A store pulses storeValid with the register value zero-extended on storeData and storeSize set to 0 for 16 bits, 1 for 32 bits and 2 for 64 bits.
- R6: Bit 9 of the second word gives the direction: 0 loads a register from memory, 1 stores it to memory.
- R7: A load of any register except the status register pulses flushReq when bit 8 of the second word is 0. No flush is requested when that bit is 1, for stores, or for the status register.
- R8: A root pointer load whose descriptor type (bits 33..32) is 00 still writes the register and pulses cfgErr.
- R9: A translation control load checks page size (bits 23..20), initial shift (bits 19..16) and the four table index fields (bits 15..12, 11..8, 7..4, 3..0). Table index fields count from the first down to the last non-zero one before a zero field. The value is still written, and cfgErr pulses if the page size plus initial shift plus the counted table index fields is not 32, or if the page size is below 8.
- R10: Loads to other registers and all stores leave the status register unchanged, and a store changes no register.
- R11: doneValid, excIllegal, excPriv, flushReq, cfgErr and storeValid are one-cycle pulses in the cycle after startValid is sampled. doneValid marks each accepted instruction, and flushReq and cfgErr coincide with the write.
- R12: After reset all six registers read as zero and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Instruction words and operand are valid this cycle |
| supervisor | input | 1 | Processor is in supervisor mode |
| opWord0 | input | 16 | First instruction word |
| opWord1 | input | 16 | Second instruction word |
| loadData | input | 64 | Operand fetched from memory for loads |
| doneValid | output | 1 | Instruction accepted and carried out |
| excIllegal | output | 1 | Illegal encoding or addressing mode |
| excPriv | output | 1 | Privilege violation |
| flushReq | output | 1 | Translation cache invalidate request |
| cfgErr | output | 1 | Loaded value failed its consistency check |
| storeValid | output | 1 | storeData holds a register value for memory |
| storeSize | output | 2 | Store width code: 0 word, 1 long, 2 quad |
| storeData | output | 64 | Zero-extended register value being stored |

## Verification
The hardest case to reach is a translation control value that passes or fails only because of how the table index fields are counted. A non-zero field after a zero one must be ignored, and a page size below 8 must fail even when the total is exactly 32. The stimulus builds these values by hand. It then stores the register back, which shows that the failing value was still written. The status register is read back after loads to every other register, so any disturbance of it shows at the store port.

// File: rtl/mmu_move_pkg.sv
package mmu_move_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_TC   = 3'd1,
    SEL_SRP  = 3'd2,
    SEL_CRP  = 3'd3,
    SEL_TT0  = 3'd4,
    SEL_TT1  = 3'd5,
    SEL_SR   = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_LONG = 2'd1,
    SZ_QUAD = 2'd2
  } xferSize_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    regSel_e sel;
  } dpStrobe_t;

  localparam logic [9:0] OPCODE_HI    = 10'b1111_0000_00;
  localparam logic [2:0] CLASS_ROOTTC = 3'b010;
  localparam logic [2:0] CLASS_TT     = 3'b000;
  localparam logic [5:0] STATUS_HI    = 6'b011000;

endpackage

// File: rtl/mmu_tc_check.sv
module mmu_tc_check #(
  parameter int FIELD_W   = 4,
  parameter int TI_COUNT  = 4,
  parameter int ADDR_BITS = 32,
  parameter int MIN_PAGE  = 8,
  localparam int CHECK_W  = (TI_COUNT + 2) * FIELD_W,
  localparam int SUM_W    = $clog2((TI_COUNT + 2) * (1 << FIELD_W)) + 1
) (
  input  logic [CHECK_W-1:0] tcVal,
  output logic               tcBad
);

  logic [FIELD_W-1:0] tiField [TI_COUNT];
  logic [FIELD_W-1:0] pageSize;
  logic [FIELD_W-1:0] initShift;

  assign pageSize  = tcVal[CHECK_W-1 -: FIELD_W];
  assign initShift = tcVal[CHECK_W-FIELD_W-1 -: FIELD_W];

  // tiField[0] is the first-level index (most significant of the group)
  genvar g;
  generate
    for (g = 0; g < TI_COUNT; g++) begin : gTi
      assign tiField[g] = tcVal[(TI_COUNT-g)*FIELD_W-1 -: FIELD_W];
    end
  endgenerate

  logic [SUM_W-1:0] total;
  logic             counting;

  always_comb begin
    total    = SUM_W'(pageSize) + SUM_W'(initShift);
    counting = 1'b1;
    for (int i = 0; i < TI_COUNT; i++) begin
      if (tiField[i] == '0) counting = 1'b0;
      if (counting) total = total + SUM_W'(tiField[i]);
    end
    tcBad = (total != SUM_W'(ADDR_BITS)) || (int'(pageSize) < MIN_PAGE);
  end

endmodule

// File: rtl/mmu_move_ctrl.sv
module mmu_move_ctrl
  import mmu_move_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              supervisor,
  input  logic [WORD_W-1:0] opWord0,
  input  logic [WORD_W-1:0] opWord1,
  output dpStrobe_t         strobe,
  output logic              doneValid,
  output logic              excIllegal,
  output logic              excPriv,
  output logic              flushReq
);

  logic [2:0] eaMode;
  logic [2:0] eaReg;
  logic       opcodeOk;
  logic       eaOk;
  regSel_e    sel;
  logic       dirStore;
  logic       noFlush;
  logic       legal;
  logic       accept;

  assign eaMode   = opWord0[5:3];
  assign eaReg    = opWord0[2:0];
  assign opcodeOk = opWord0[15:6] == OPCODE_HI;

  always_comb begin
    unique case (eaMode)
      3'b010, 3'b101, 3'b110: eaOk = 1'b1;
      3'b111:                 eaOk = (eaReg == 3'b000) || (eaReg == 3'b001);
      default:                eaOk = 1'b0;
    endcase
  end

  // second-word register selection and flags
  always_comb begin
    sel      = SEL_NONE;
    dirStore = opWord1[9];
    noFlush  = opWord1[8];
    if (opWord1[15:10] == STATUS_HI && opWord1[8:0] == '0) begin
      sel     = SEL_SR;
      noFlush = 1'b1;
    end else if (opWord1[7:0] == '0) begin
      if (opWord1[15:13] == CLASS_ROOTTC) begin
        unique case (opWord1[12:10])
          3'b000:  sel = SEL_TC;
          3'b010:  sel = SEL_SRP;
          3'b011:  sel = SEL_CRP;
          default: sel = SEL_NONE;
        endcase
      end else if (opWord1[15:13] == CLASS_TT) begin
        unique case (opWord1[12:10])
          3'b010:  sel = SEL_TT0;
          3'b011:  sel = SEL_TT1;
          default: sel = SEL_NONE;
        endcase
      end
    end
  end

  assign legal  = opcodeOk && eaOk && (sel != SEL_NONE);
  assign accept = startValid && supervisor && legal;

  always_comb begin
    strobe.wrEn = accept && !dirStore;
    strobe.rdEn = accept && dirStore;
    strobe.sel  = sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      excIllegal <= 1'b0;
      excPriv    <= 1'b0;
      flushReq   <= 1'b0;
    end else begin
      doneValid  <= accept;
      excPriv    <= startValid && !supervisor;
      excIllegal <= startValid && supervisor && !legal;
      flushReq   <= accept && !dirStore && !noFlush;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn)); // R6
  AST_PRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !supervisor) |=> excPriv && !doneValid && !excIllegal); // R3

endmodule

// File: rtl/mmu_move_dp.sv
module mmu_move_dp
  import mmu_move_pkg::*;
#(
  parameter int ROOT_W    = 64,
  parameter int CTRL_W    = 32,
  parameter int STAT_W    = 16,
  parameter int DT_LSB    = 32,
  parameter int FIELD_W   = 4,
  parameter int TI_COUNT  = 4,
  parameter int ADDR_BITS = 32,
  parameter int MIN_PAGE  = 8,
  localparam int CHECK_W  = (TI_COUNT + 2) * FIELD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ROOT_W-1:0] loadData,
  output logic              cfgErr,
  output logic              storeValid,
  output logic [1:0]        storeSize,
  output logic [ROOT_W-1:0] storeData
);

  logic [ROOT_W-1:0] crpReg, srpReg;
  logic [CTRL_W-1:0] tcReg, tt0Reg, tt1Reg;
  logic [STAT_W-1:0] srReg;

  logic tcBad;
  logic rootBad;
  logic errNext;

  mmu_tc_check #(
    .FIELD_W  (FIELD_W),
    .TI_COUNT (TI_COUNT),
    .ADDR_BITS(ADDR_BITS),
    .MIN_PAGE (MIN_PAGE)
  ) u_tcCheck (
    .tcVal(loadData[CHECK_W-1:0]),
    .tcBad(tcBad)
  );

  assign rootBad = loadData[DT_LSB+1:DT_LSB] == 2'b00;

  always_comb begin
    unique case (strobe.sel)
      SEL_SRP, SEL_CRP: errNext = rootBad;
      SEL_TC:           errNext = tcBad;
      default:          errNext = 1'b0;
    endcase
  end

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crpReg <= '0;
      srpReg <= '0;
      tcReg  <= '0;
      tt0Reg <= '0;
      tt1Reg <= '0;
      srReg  <= '0;
    end else if (strobe.wrEn) begin
      unique case (strobe.sel)
        SEL_CRP: crpReg <= loadData;
        SEL_SRP: srpReg <= loadData;
        SEL_TC:  tcReg  <= loadData[CTRL_W-1:0];
        SEL_TT0: tt0Reg <= loadData[CTRL_W-1:0];
        SEL_TT1: tt1Reg <= loadData[CTRL_W-1:0];
        SEL_SR:  srReg  <= loadData[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  logic [ROOT_W-1:0] rdData;
  xferSize_e         rdSize;

  always_comb begin
    rdData = '0;
    rdSize = SZ_LONG;
    unique case (strobe.sel)
      SEL_CRP: begin rdData = crpReg;           rdSize = SZ_QUAD; end
      SEL_SRP: begin rdData = srpReg;           rdSize = SZ_QUAD; end
      SEL_TC:  rdData = ROOT_W'(tcReg);
      SEL_TT0: rdData = ROOT_W'(tt0Reg);
      SEL_TT1: rdData = ROOT_W'(tt1Reg);
      SEL_SR:  begin rdData = ROOT_W'(srReg);   rdSize = SZ_WORD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr     <= 1'b0;
      storeValid <= 1'b0;
      storeSize  <= 2'd0;
      storeData  <= '0;
    end else begin
      cfgErr     <= strobe.wrEn && errNext;
      storeValid <= strobe.rdEn;
      storeSize  <= strobe.rdEn ? 2'(rdSize) : 2'd0;
      storeData  <= strobe.rdEn ? rdData : '0;
    end
  end

  AST_SR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrEn || strobe.sel != SEL_SR) |=> $stable(srReg)); // R10
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> $stable(crpReg) && $stable(srpReg) && $stable(tcReg)); // R10
  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !storeValid |-> storeData == '0); // R5

endmodule

// File: rtl/mmu_move_unit.sv
module mmu_move_unit
  import mmu_move_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ROOT_W    = 64,
  parameter int CTRL_W    = 32,
  parameter int STAT_W    = 16,
  parameter int DT_LSB    = 32,
  parameter int FIELD_W   = 4,
  parameter int TI_COUNT  = 4,
  parameter int ADDR_BITS = 32,
  parameter int MIN_PAGE  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              supervisor,
  input  logic [WORD_W-1:0] opWord0,
  input  logic [WORD_W-1:0] opWord1,
  input  logic [ROOT_W-1:0] loadData,
  output logic              doneValid,
  output logic              excIllegal,
  output logic              excPriv,
  output logic              flushReq,
  output logic              cfgErr,
  output logic              storeValid,
  output logic [1:0]        storeSize,
  output logic [ROOT_W-1:0] storeData
);

  dpStrobe_t strobe;

  mmu_move_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .supervisor(supervisor),
    .opWord0   (opWord0),
    .opWord1   (opWord1),
    .strobe    (strobe),
    .doneValid (doneValid),
    .excIllegal(excIllegal),
    .excPriv   (excPriv),
    .flushReq  (flushReq)
  );

  mmu_move_dp #(
    .ROOT_W   (ROOT_W),
    .CTRL_W   (CTRL_W),
    .STAT_W   (STAT_W),
    .DT_LSB   (DT_LSB),
    .FIELD_W  (FIELD_W),
    .TI_COUNT (TI_COUNT),
    .ADDR_BITS(ADDR_BITS),
    .MIN_PAGE (MIN_PAGE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadData  (loadData),
    .cfgErr    (cfgErr),
    .storeValid(storeValid),
    .storeSize (storeSize),
    .storeData (storeData)
  );

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(excIllegal && excPriv)); // R3
  AST_EXC_NO_WORK: assert property (@(posedge clk) disable iff (!rstN)
    (excIllegal || excPriv) |-> !doneValid && !storeValid && !flushReq); // R1
  AST_FLUSH_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> doneValid && !storeValid); // R7
  AST_CFG_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> doneValid && !storeValid); // R8
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(startValid)); // R11

endmodule

// File: tb/mmu_move_unit_bench.sv
module mmu_move_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        supervisor = 1'b1;
  logic [15:0] opWord0 = '0;
  logic [15:0] opWord1 = '0;
  logic [63:0] loadData = '0;
  logic        doneValid, excIllegal, excPriv, flushReq, cfgErr, storeValid;
  logic [1:0]  storeSize;
  logic [63:0] storeData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mmu_move_unit u_mmu_move_unit (
    .clk(clk), .rstN(rstN), .startValid(startValid), .supervisor(supervisor),
    .opWord0(opWord0), .opWord1(opWord1), .loadData(loadData),
    .doneValid(doneValid), .excIllegal(excIllegal), .excPriv(excPriv),
    .flushReq(flushReq), .cfgErr(cfgErr), .storeValid(storeValid),
    .storeSize(storeSize), .storeData(storeData)
  );

  // reference model state, indexed by name
  logic [63:0] model [string];
  logic [71:0] expOut;

  function automatic logic [71:0] packOut(logic d, logic il, logic pv, logic fl,
                                          logic ce, logic sv, logic [1:0] sz,
                                          logic [63:0] sd);
    return {d, il, pv, fl, ce, sv, sz, sd};
  endfunction

  function automatic bit tcFails(logic [31:0] v);
    int total = v[23:20] + v[19:16];
    bit stop = 0;
    int f;
    for (int k = 3; k >= 0; k--) begin
      f = (v >> (k * 4)) & 32'hF;
      if (f == 0) stop = 1;
      if (!stop) total += f;
    end
    return (total != 32) || (v[23:20] < 8);
  endfunction

  // behavioural reference: produce the expected output vector for one instruction
  function automatic logic [71:0] predict(logic [15:0] w0, logic [15:0] w1,
                                          logic [63:0] data, logic sup);
    string name = "";
    int bits = 0;
    bit legalEa;
    bit store, fd, err;
    logic [63:0] val;
    if (!sup) return packOut(0, 0, 1, 0, 0, 0, 0, 0);
    case (w0[5:3])
      3'd2, 3'd5, 3'd6: legalEa = 1;
      3'd7:             legalEa = w0[2:0] < 2;
      default:          legalEa = 0;
    endcase
    if (w0[15:6] != 10'h3C0) legalEa = 0;
    store = w1[9];
    fd = w1[8];
    if (w1[15:10] == 6'h18 && w1[8:0] == 0) begin name = "sr"; bits = 16; fd = 1; end
    else if (w1[7:0] == 0 && w1[15:13] == 3'd2 && w1[12:10] == 0) begin name = "tc"; bits = 32; end
    else if (w1[7:0] == 0 && w1[15:13] == 3'd2 && w1[12:10] == 2) begin name = "srp"; bits = 64; end
    else if (w1[7:0] == 0 && w1[15:13] == 3'd2 && w1[12:10] == 3) begin name = "crp"; bits = 64; end
    else if (w1[7:0] == 0 && w1[15:13] == 3'd0 && w1[12:10] == 2) begin name = "tt0"; bits = 32; end
    else if (w1[7:0] == 0 && w1[15:13] == 3'd0 && w1[12:10] == 3) begin name = "tt1"; bits = 32; end
    if (!legalEa || bits == 0) return packOut(0, 1, 0, 0, 0, 0, 0, 0);
    if (store) begin
      val = model[name];
      return packOut(1, 0, 0, 0, 0, 1, (bits == 64) ? 2'd2 : (bits == 32) ? 2'd1 : 2'd0, val);
    end
    val = (bits == 64) ? data : (bits == 32) ? {32'h0, data[31:0]} : {48'h0, data[15:0]};
    model[name] = val;
    err = 0;
    if (bits == 64) err = (data[33:32] == 2'b00);
    if (name == "tc") err = tcFails(data[31:0]);
    return packOut(1, 0, 0, !fd, err, 0, 0, 0);
  endfunction

  task automatic compare(string req);
    logic [71:0] act = packOut(doneValid, excIllegal, excPriv, flushReq, cfgErr,
                               storeValid, storeSize, storeData);
    checks++;
    if (act !== expOut) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expOut);
    end
  endtask

  // issue at a negedge, compare the result cycle, then compare the idle cycle
  task automatic issue(string req, logic [15:0] w0, logic [15:0] w1,
                       logic [63:0] data, logic sup = 1'b1);
    opWord0 = w0; opWord1 = w1; loadData = data; supervisor = sup;
    startValid = 1'b1;
    expOut = predict(w0, w1, data, sup);
    @(negedge clk);
    startValid = 1'b0;
    compare(req);
    expOut = '0;
    @(negedge clk);
    compare("R11");
  endtask

  localparam logic [15:0] W0_AN   = 16'hF010;
  localparam logic [15:0] W0_D16  = 16'hF028;
  localparam logic [15:0] W0_IDX  = 16'hF030;
  localparam logic [15:0] W0_ABSL = 16'hF039;
  localparam logic [15:0] W0_ABSW = 16'hF038;

  initial begin
    model["crp"] = 0; model["srp"] = 0; model["tc"] = 0;
    model["tt0"] = 0; model["tt1"] = 0; model["sr"] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expOut = '0;
    compare("R12");
    // R12: every register reads as zero after reset
    issue("R12", W0_AN, 16'h4E00, 0);
    issue("R12", W0_AN, 16'h4A00, 0);
    issue("R12", W0_AN, 16'h4200, 0);
    issue("R12", W0_AN, 16'h0A00, 0);
    issue("R12", W0_AN, 16'h0E00, 0);
    issue("R12", W0_AN, 16'h6200, 0);
    // R4 R6 R7: loads with flush, then read back
    issue("R4", W0_AN, 16'h6000, 64'hFFFF_FFFF_FFFF_BEEF);
    issue("R7", W0_D16, 16'h4C00, 64'h1234_5602_89AB_CDEF);
    issue("R5", W0_AN, 16'h4E00, 0);
    issue("R7", W0_IDX, 16'h4900, 64'h0000_0003_0000_1000);
    issue("R5", W0_AN, 16'h4A00, 0);
    issue("R4", W0_ABSL, 16'h0800, 64'hAAAA_AAAA_1357_9BDF);
    issue("R4", W0_ABSW, 16'h0D00, 64'h5555_5555_2468_ACE0);
    issue("R5", W0_AN, 16'h0A00, 0);
    issue("R5", W0_AN, 16'h0E00, 0);
    // R8: invalid descriptor type still written
    issue("R8", W0_AN, 16'h4C00, 64'hABCD_0000_0000_1000);
    issue("R8", W0_AN, 16'h4E00, 0);
    issue("R8", W0_AN, 16'h4800, 64'h0000_0001_0000_0000);
    // R9: translation control consistency
    issue("R9", W0_AN, 16'h4000, 64'h0000_0000_00C0_AA00);
    issue("R9", W0_AN, 16'h4000, 64'h0000_0000_00C0_AA05);
    issue("R9", W0_AN, 16'h4200, 0);
    issue("R9", W0_AN, 16'h4000, 64'h0000_0000_00C0_AB00);
    issue("R9", W0_AN, 16'h4200, 0);
    issue("R9", W0_AN, 16'h4100, 64'h0000_0000_0071_8880);
    issue("R9", W0_AN, 16'h4000, 64'h0000_0000_8082_8888);
    issue("R9", W0_AN, 16'h4000, 64'h0000_0000_00D3_4340);
    // R10: status survived everything above
    issue("R10", W0_AN, 16'h6200, 0);
    // R1: illegal first words, followed by read-back showing no write
    issue("R1", 16'hF000, 16'h0800, 64'h1111);
    issue("R1", 16'hF03A, 16'h0800, 64'h2222);
    issue("R1", 16'hF018, 16'h0800, 64'h3333);
    issue("R1", 16'hF110, 16'h0800, 64'h4444);
    issue("R1", W0_AN, 16'h0A00, 0);
    // R2: illegal second words
    issue("R2", W0_AN, 16'h4400, 64'h5555);
    issue("R2", W0_AN, 16'h0000, 64'h5555);
    issue("R2", W0_AN, 16'h0801, 64'h5555);
    issue("R2", W0_AN, 16'h6100, 64'h5555);
    issue("R2", W0_AN, 16'h2800, 64'h5555);
    issue("R2", W0_AN, 16'h6200, 0);
    // R3: user mode, legal and illegal encodings
    issue("R3", W0_AN, 16'h6000, 64'h7777, 1'b0);
    issue("R3", 16'hF000, 16'h4400, 64'h7777, 1'b0);
    issue("R3", W0_AN, 16'h6200, 0);
    // R11: back-to-back start without idle
    opWord0 = W0_AN; opWord1 = 16'h0800; loadData = 64'h0000_0000_0BAD_F00D;
    startValid = 1'b1;
    expOut = predict(W0_AN, 16'h0800, loadData, 1'b1);
    @(negedge clk);
    compare("R11");
    opWord1 = 16'h0A00;
    expOut = predict(W0_AN, 16'h0A00, 0, 1'b1);
    @(negedge clk);
    startValid = 1'b0;
    compare("R11");
    expOut = '0;
    @(negedge clk);
    compare("R11");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule